// File: doc/BRIEF.md
# Multi-Mode Converter Serial Readout

This block sits on the device side of a 12-bit converter. It takes each finished conversion word from the core and sends it to a host over a three-wire serial link: a serial clock, a data line and an active-low frame signal. The core marks a finished word with a single-cycle `word_valid` strobe, and the word arrives with it on `word_in`. The block holds the word and shifts it out MSB first. It drives the data line only while the frame is low.

Two static straps choose one of four framing modes. `strap_len16` selects a 14- or 16-clock frame. `strap_cont` selects a burst or a continuous serial clock. In the burst 14-clock mode the block makes the serial clock itself from the system clock. In the other three modes the host supplies the clock on `sclk_in`. The block samples that clock with a two-stage synchronizer and acts on its edges.

`idle_hi` sets the level the serial clock rests at. An edge that leaves the idle level is a capture edge, where the host latches data. An edge that returns to idle is a launch edge, where the block moves to the next bit. A format input can flip the word's MSB, which turns an offset-binary core code into two's complement for bipolar ranges.

Top module: `adc_serial_tx`

## Requirements
- R1: The mode is set by (`strap_len16`,`strap_cont`): (0,0) generated burst, 14 clocks; (0,1) continuous, 14-bit frame; (1,0) host burst, 16 clocks; (1,1) continuous, 16-bit frame. `sclk_oe` is 1 only in the (0,0) mode.
- R2: In the generated-burst mode the block produces exactly 14 clock cycles after a strobe, then rests at the idle level. Frame goes low on the 2nd launch edge, so the 12 word bits sit on capture edges 3 to 14. Frame goes high on the 14th launch edge.
- R3: In the continuous 14-bit mode, frame goes low on the first launch edge after the strobe. The next 14 capture edges carry two zero bits and then the 12-bit word. Frame goes high on the 15th launch edge.
- R4: In the host-burst mode, frame goes low within two system clocks of the strobe. The 16 capture edges carry four zero bits and then the word. Frame goes high on the 16th launch edge, when the clock returns to idle.
- R5: In the continuous 16-bit mode, frame goes low on the first launch edge after the strobe. The next 16 capture edges carry four zero bits and then the word. Frame goes high on the 17th launch edge.
- R6: With `idle_hi`=1 the capture edge is falling and the launch edge is rising. With `idle_hi`=0 both are reversed. The generated clock rests at the `idle_hi` level.
- R7: Bits go out MSB first: any zero padding bits, then word bit 11 down to bit 0.
- R8: With `fmt_twos`=1 the sent word is `word_in` with bit 11 inverted. With `fmt_twos`=0 it is `word_in` unchanged.
- R9: `sdata_oe` is 1 exactly while `frame_n` is 0. `sdata` is 0 whenever `frame_n` is 1.
- R10: A strobe that arrives while a frame is pending or in progress is ignored, so the frame in flight sends its original word. It sets `overrun`, which stays 1 until reset.
- R11: After reset: `frame_n`=1, `sdata_oe`=0, `overrun`=0, and `sclk_o` equals `idle_hi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| word_valid | input | 1 | Conversion-done strobe, one clock |
| word_in | input | 12 | Conversion result, offset binary |
| fmt_twos | input | 1 | 1: invert MSB (two's complement) |
| strap_len16 | input | 1 | 1: 16-clock frame, 0: 14-clock frame |
| strap_cont | input | 1 | 1: continuous host clock, 0: burst |
| idle_hi | input | 1 | Idle level of the serial clock |
| sclk_in | input | 1 | Serial clock from host |
| sclk_o | output | 1 | Generated serial clock |
| sclk_oe | output | 1 | Drive enable for `sclk_o` |
| sdata | output | 1 | Serial data |
| sdata_oe | output | 1 | Drive enable for `sdata` |
| frame_n | output | 1 | Active-low frame |
| overrun | output | 1 | Sticky ignored-strobe flag |

## Verification
A wrong bit index or preamble count shows up on the very frame in which it happens. The number of bits sampled while the frame is low comes out wrong, or the word shifts by one place. Either one shows at the host's capture edges within 16 serial clocks.

A busy flag that never clears makes the next strobe set `overrun` and produce no frame at all. A generated clock that does not stop shows extra capture edges after the frame ends. Each scenario counts captures and bits and compares the whole frame, so these faults appear at the end of the first frame they touch.

// File: rtl/adc_serial_tx.sv
module adc_serial_tx #(
  parameter int WORD_W   = 12,
  parameter int DIV_HALF = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_in,
  input  logic              fmt_twos,
  input  logic              strap_len16,
  input  logic              strap_cont,
  input  logic              idle_hi,
  input  logic              sclk_in,
  output logic              sclk_o,
  output logic              sclk_oe,
  output logic              sdata,
  output logic              sdata_oe,
  output logic              frame_n,
  output logic              overrun
);
  localparam int FRAME_MAX = WORD_W + 4;
  localparam int IDX_W     = $clog2(FRAME_MAX);
  localparam int DIV_W     = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [IDX_W-1:0] IDX_GEN  = IDX_W'(WORD_W - 1);
  localparam logic [IDX_W-1:0] IDX_SHORT = IDX_W'(WORD_W + 1);
  localparam logic [IDX_W-1:0] IDX_LONG  = IDX_W'(WORD_W + 3);

  logic              gen_mode, host_burst;
  logic              busy, fa;
  logic [1:0]        pre;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] word_q;
  logic [FRAME_MAX-1:0] frame_word;
  logic              s1, s2, s3;
  logic              gphase;
  logic [DIV_W-1:0]  div_cnt;
  logic              ext_launch, gen_tick, gen_launch, launch;

  assign gen_mode   = !strap_len16 && !strap_cont;
  assign host_burst = strap_len16 && !strap_cont;
  assign frame_word = {4'b0000, word_q};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s1, s2, s3} <= 3'b000;
    else        {s1, s2, s3} <= {sclk_in, s1, s2};

  assign ext_launch = !gen_mode && ((s2 ^ idle_hi) == 1'b0) && ((s3 ^ idle_hi) == 1'b1);
  assign gen_tick   = gen_mode && busy && (div_cnt == DIV_W'(DIV_HALF - 1));
  assign gen_launch = gen_tick && gphase;
  assign launch     = busy && (gen_mode ? gen_launch : ext_launch);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_cnt <= '0;
      gphase  <= 1'b0;
    end else if (!(gen_mode && busy)) begin
      div_cnt <= '0;
      gphase  <= 1'b0;
    end else if (gen_tick) begin
      div_cnt <= '0;
      gphase  <= !gphase;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy    <= 1'b0;
      fa      <= 1'b0;
      pre     <= '0;
      idx     <= '0;
      word_q  <= '0;
      overrun <= 1'b0;
    end else begin
      if (word_valid && busy) overrun <= 1'b1;
      if (word_valid && !busy) begin
        busy   <= 1'b1;
        word_q <= word_in ^ (WORD_W'(fmt_twos) << (WORD_W - 1));
        fa     <= host_burst;
        idx    <= IDX_LONG;
        pre    <= gen_mode ? 2'd2 : 2'd1;
      end else if (launch) begin
        if (!fa) begin
          pre <= pre - 1'b1;
          if (pre == 2'd1) begin
            fa  <= 1'b1;
            idx <= gen_mode ? IDX_GEN : (strap_len16 ? IDX_LONG : IDX_SHORT);
          end
        end else if (idx == '0) begin
          fa   <= 1'b0;
          busy <= 1'b0;
        end else begin
          idx <= idx - 1'b1;
        end
      end
    end

  assign sclk_o   = gphase ^ idle_hi;
  assign sclk_oe  = gen_mode;
  assign frame_n  = !fa;
  assign sdata_oe = fa;
  assign sdata    = fa && frame_word[idx];

  AST_CLK_RESTS:   assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (sclk_o == idle_hi));                 // R6
  AST_OVR_STICKY:  assert property (@(posedge clk) disable iff (!rst_n) overrun |=> overrun);                           // R10
  AST_OVR_IGNORE:  assert property (@(posedge clk) disable iff (!rst_n) (word_valid && busy) |=> $stable(word_q));      // R10
  AST_QUIET_LINE:  assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (frame_n && !sdata));                 // R9
  AST_GEN_END:     assert property (@(posedge clk) disable iff (!rst_n) (gen_mode && $rose(frame_n)) |-> (sclk_o == idle_hi)); // R2
  AST_PAD_ZERO:    assert property (@(posedge clk) disable iff (!rst_n) (fa && idx >= IDX_W'(WORD_W)) |-> !sdata);      // R7
endmodule

// File: tb/tb_adc_serial_tx.sv
module tb_adc_serial_tx;
  localparam int CLK_PERIOD = 10;
  localparam int H = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic word_valid = 1'b0, fmt_twos = 1'b0, strap_len16 = 1'b0, strap_cont = 1'b0;
  logic idle_hi = 1'b1, sclk_in = 1'b1;
  logic [11:0] word_in = '0;
  logic sclk_o, sclk_oe, sdata, sdata_oe, frame_n, overrun;

  int checks = 0, fails = 0;

  adc_serial_tx dut (.clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_in(word_in),
    .fmt_twos(fmt_twos), .strap_len16(strap_len16), .strap_cont(strap_cont), .idle_hi(idle_hi),
    .sclk_in(sclk_in), .sclk_o(sclk_o), .sclk_oe(sclk_oe), .sdata(sdata), .sdata_oe(sdata_oe),
    .frame_n(frame_n), .overrun(overrun));

  always #(CLK_PERIOD/2) clk = !clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [11:0] w);
    word_in = w; word_valid = 1'b1;
    @(negedge clk);
    word_valid = 1'b0;
  endtask

  // host-clocked modes (R3, R4, R5), optional overrun stimulus (R10)
  task automatic run_host(input bit len16, input bit cont, input bit idle, input bit twos,
                          input logic [11:0] w, input string req, input bit ovr);
    int n = len16 ? 16 : 14;
    int ncyc = cont ? n + 2 : n;
    int cnt = 0, oe_bad = 0;
    logic [15:0] got = '0;
    logic [15:0] exp = {4'b0000, w ^ (12'(twos) << 11)};
    strap_len16 = len16; strap_cont = cont; idle_hi = idle; fmt_twos = twos; sclk_in = idle;
    repeat (H) @(negedge clk);
    strobe(w);
    repeat (H) @(negedge clk);
    for (int k = 1; k <= ncyc; k++) begin
      if (!frame_n) begin
        got = {got[14:0], sdata}; cnt++;
        if (!sdata_oe) oe_bad++;
      end else if (sdata_oe || sdata) oe_bad++;
      sclk_in = !idle;
      repeat (H) @(negedge clk);
      sclk_in = idle;
      if (ovr && k == 5) begin
        word_in = ~w; word_valid = 1'b1;
        @(negedge clk);
        word_valid = 1'b0;
        repeat (H-1) @(negedge clk);
      end else repeat (H) @(negedge clk);
    end
    chk(cnt == n, {req, " bit count in frame"}, cnt, n);
    chk(got == (exp & ((17'h1 << n) - 1)), {req, " R7 R8 word"}, got, exp);
    chk(frame_n == 1'b1, {req, " frame ends"}, frame_n, 1);
    chk(oe_bad == 0, {req, " R9 enable follows frame"}, oe_bad, 0);
  endtask

  // generated burst mode (R2)
  task automatic run_gen(input bit idle, input bit twos, input logic [11:0] w);
    int caps = 0, cnt = 0, first = 0;
    logic prev;
    logic [11:0] got = '0;
    logic [11:0] exp = w ^ (12'(twos) << 11);
    strap_len16 = 1'b0; strap_cont = 1'b0; idle_hi = idle; fmt_twos = twos; sclk_in = idle;
    repeat (H) @(negedge clk);
    chk(sclk_oe == 1'b1, "R1 clock driven in generated mode", sclk_oe, 1);
    chk(sclk_o == idle, "R6 generated clock rests at idle", sclk_o, idle);
    strobe(w);
    prev = sclk_o;
    for (int t = 0; t < 400; t++) begin
      @(negedge clk);
      if (sclk_o != prev && sclk_o != idle) begin
        caps++;
        if (!frame_n) begin
          got = {got[10:0], sdata}; cnt++;
          if (first == 0) first = caps;
        end
      end
      prev = sclk_o;
    end
    chk(caps == 14, "R2 exactly 14 generated cycles", caps, 14);
    chk(first == 3, "R2 first data capture edge", first, 3);
    chk(cnt == 12 && got == exp, "R2 R8 generated word", got, exp);
    chk(frame_n && sclk_o == idle, "R2 R6 frame ends, clock idle", {frame_n, sclk_o}, {1'b1, idle});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(frame_n == 1'b1 && sdata_oe == 1'b0, "R11 reset frame/enable", {frame_n, sdata_oe}, 2'b10);
    chk(overrun == 1'b0, "R11 reset overrun", overrun, 0);
    chk(sclk_o == idle_hi, "R11 reset clock level", sclk_o, idle_hi);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    run_host(1, 1, 1, 0, 12'hA5C, "R5 cont16 idle1", 0);
    run_host(1, 1, 0, 0, 12'h3C1, "R5 R6 cont16 idle0", 0);
    run_host(0, 1, 1, 1, 12'h123, "R3 cont14 idle1 twos", 0);
    run_host(1, 0, 1, 1, 12'hF0F, "R4 burst16 idle1 twos", 0);
    run_host(1, 0, 0, 0, 12'h801, "R4 R6 burst16 idle0", 0);
    chk(sclk_oe == 1'b0, "R1 clock not driven in host mode", sclk_oe, 0);
    run_gen(1, 0, 12'h9B4);
    run_gen(0, 1, 12'h07E);
    chk(overrun == 1'b0, "R10 no overrun yet", overrun, 0);
    run_host(1, 1, 1, 0, 12'h5A6, "R10 frame keeps word", 1);
    chk(overrun == 1'b1, "R10 overrun set", overrun, 1);
    run_host(0, 1, 1, 0, 12'hC33, "R10 R3 next frame after overrun", 0);
    chk(overrun == 1'b1, "R10 overrun sticky", overrun, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule